// File: doc/BRIEF.md
# Fractional Clock Divider Core

This block turns a fast clock into a slower event stream whose average rate is n/m of the input rate, with n and m as any integers where n ≤ m. The slower stream is delivered in one of two ways. The first is a one-cycle enable pulse. The second is a divided clock whose high time is close to half of each output period.

Each cycle the core steps a phase accumulator by one of two programmed terms. It never counts whole input periods, so it can reach ratios that an integer divider cannot, such as 12 MHz from a 13 MHz source. Software works out the terms and places them in the two fields. Both terms may be shifted left by the same amount to use more of the field width, and the ratio stays the same.

A parameter selects the field width: 8 bits by default, or 13 bits for the wide variant.

Top module: `fdiv_core`

## Requirements
- R1: While rst_ni is low, pulse_o and clk_o are 0 and the accumulator is zero.
- R2: When run_i is sampled low at a rising edge, the accumulator returns to zero and both outputs are 0 after that edge. The first rising edge with run_i high therefore always produces a pulse.
- R3: The add field holds m−n. The subtract field holds the low FW bits of −n, and its sign is implied rather than stored. A subtract field f therefore means n = 2^FW − f, so f = 0 stands for n = 2^FW.
- R4: Starting from an idle core, any 2m consecutive enabled cycles contain exactly 2n pulses.
- R5: At each enabled edge, an accumulator value a below n gives a pulse and the accumulator becomes a + (m−n). Any other value gives no pulse and the accumulator becomes a − n. pulse_o shows the decision for the cycle after the edge.
- R6: Shifting both fields left by the same amount gives the same pulse sequence, cycle for cycle.
- R7: With stretch_i high, clk_o after an enabled edge is 1 exactly when twice the new accumulator value is less than m. The high time is therefore about half of each period.
- R8: With stretch_i low, clk_o equals pulse_o.
- R9: When the add field is zero (n = m), a pulse occurs on every enabled cycle.
- R10: With WIDE_FIELD set, both fields are 13 bits wide and R3 to R5 apply with FW = 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables the divider; low clears the accumulator |
| stretch_i | input | 1 | Selects the half-duty divided clock on clk_o |
| madd_i | input | FW | Add term, m−n |
| msub_i | input | FW | Subtract term, the low bits of −n |
| pulse_o | output | 1 | One-cycle enable pulse at rate n/m |
| clk_o | output | 1 | Divided clock (stretch) or a copy of the pulse |

## Verification
Both outputs are registered. Each reflects the inputs and the accumulator sampled at one rising edge and is valid from that edge until the next. The bench changes its inputs on falling edges. After each rising edge it advances an arithmetic model of the accumulator by exactly one step and compares both outputs at the following falling edge. As a result, the first enabled edge after an idle period is matched to the first model step.

The sweep covers every n ≤ m ≤ 16, both unshifted and at the largest shift that fits, in both output modes. It also runs a few wide-field ratios.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned WIDE_W   = 13;

  function automatic int unsigned field_width(bit wide);
    return wide ? WIDE_W : NARROW_W;
  endfunction
endpackage

// File: rtl/fdiv_field_decode.sv
module fdiv_field_decode #(
  parameter int unsigned FW = 8
) (
  input  logic [FW-1:0] madd_i,
  input  logic [FW-1:0] msub_i,
  output logic [FW:0]   sub_mag_o,
  output logic [FW:0]   period_o
);
  localparam logic [FW:0] FULL = (FW+1)'(1) << FW;

  // subtract field carries an implied sign bit: n = 2^FW - f
  assign sub_mag_o = FULL - {1'b0, msub_i};
  assign period_o  = sub_mag_o + {1'b0, madd_i};
endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int unsigned FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [FW-1:0] add_i,
  input  logic [FW:0]   sub_mag_i,
  input  logic [FW:0]   period_i,
  output logic          borrow_o,
  output logic [FW:0]   acc_next_o,
  output logic [FW:0]   acc_o,
  output logic          pulse_o
);
  logic [FW:0]   acc_q;
  logic          pulse_q;
  logic [FW+1:0] diff;

  assign diff       = {1'b0, acc_q} - {1'b0, sub_mag_i};
  assign borrow_o   = diff[FW+1];
  assign acc_next_o = borrow_o ? acc_q + {1'b0, add_i} : diff[FW:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!run_i) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_next_o;
      pulse_q <= borrow_o;
    end
  end

  assign acc_o   = acc_q;
  assign pulse_o = pulse_q;

  // R2
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (acc_q == '0 && !pulse_q));

  // R5
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && $stable(period_i) && $stable(sub_mag_i) &&
     $past(acc_q < period_i)) |-> acc_q < period_i);

  // R9
  unity_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && $past(add_i) == '0 && $past(acc_q) == '0)
      |-> (pulse_q && acc_q == '0));
endmodule

// File: rtl/fdiv_out.sv
module fdiv_out #(
  parameter int unsigned FW = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        stretch_i,
  input  logic        borrow_i,
  input  logic [FW:0] acc_next_i,
  input  logic [FW:0] period_i,
  input  logic        pulse_i,
  output logic        clk_o
);
  logic clk_q;
  logic low_half;

  // high while 2*acc < m, scale-invariant midpoint test
  assign low_half = {acc_next_i, 1'b0} < {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        clk_q <= 1'b0;
    else if (!run_i)    clk_q <= 1'b0;
    else if (stretch_i) clk_q <= low_half;
    else                clk_q <= borrow_i;
  end

  assign clk_o = clk_q;

  // R8
  pulse_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$past(stretch_i)) |-> clk_o == pulse_i);

  // R2
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> !clk_o);
endmodule

// File: rtl/fdiv_core.sv
module fdiv_core import fdiv_pkg::*; #(
  parameter bit WIDE_FIELD = 1'b0,
  localparam int unsigned FW = field_width(WIDE_FIELD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          stretch_i,
  input  logic [FW-1:0] madd_i,
  input  logic [FW-1:0] msub_i,
  output logic          pulse_o,
  output logic          clk_o
);
  logic [FW:0] sub_mag;
  logic [FW:0] period;
  logic        borrow;
  logic [FW:0] acc_next;
  logic [FW:0] acc;

  fdiv_field_decode #(.FW(FW)) i_decode (
    .madd_i    (madd_i),
    .msub_i    (msub_i),
    .sub_mag_o (sub_mag),
    .period_o  (period)
  );

  fdiv_accum #(.FW(FW)) i_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .add_i      (madd_i),
    .sub_mag_i  (sub_mag),
    .period_i   (period),
    .borrow_o   (borrow),
    .acc_next_o (acc_next),
    .acc_o      (acc),
    .pulse_o    (pulse_o)
  );

  fdiv_out #(.FW(FW)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .stretch_i  (stretch_i),
    .borrow_i   (borrow),
    .acc_next_i (acc_next),
    .period_i   (period),
    .pulse_i    (pulse_o),
    .clk_o      (clk_o)
  );

  // R1
  always_comb begin
    if (!rst_ni) reset_state_chk: assert (acc == '0 && !pulse_o && !clk_o);
  end
endmodule

// File: tb/test_fdiv_core.sv
`timescale 1ns/1ps
module test_fdiv_core;
  localparam int W  = 8;
  localparam int WW = 13;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, stretch = 1'b0;
  logic [W-1:0]  madd = '0, msub = '0;
  logic [WW-1:0] madd_w = '0, msub_w = '0;
  logic pulse, dclk, pulse_w, dclk_w;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  fdiv_core i_fdiv_core (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .stretch_i(stretch),
    .madd_i(madd), .msub_i(msub), .pulse_o(pulse), .clk_o(dclk));

  fdiv_core #(.WIDE_FIELD(1'b1)) i_fdiv_core_wide (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .stretch_i(stretch),
    .madd_i(madd_w), .msub_i(msub_w), .pulse_o(pulse_w), .clk_o(dclk_w));

  task automatic check(string req, int act, int exp, string ctx);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, ctx, act, exp);
    end
  endtask

  // one configuration: 2m enabled cycles from idle, model stepped per edge
  task automatic run_cfg(bit wide, int n, int m, int s, bit str,
                         output logic [63:0] seq, output int npulse);
    int fw, ne, me, a, p, ec, ap, ac;
    string ctx;
    fw = wide ? WW : W;
    ne = n << s;
    me = m << s;
    seq = '0;
    npulse = 0;
    ctx = $sformatf("n=%0d m=%0d s=%0d str=%0d w=%0d", n, m, s, str, wide);
    @(negedge clk);
    run = 1'b0;
    stretch = str;
    if (wide) begin
      madd_w = WW'((m - n) << s);
      msub_w = WW'((1 << fw) - ne);
    end else begin
      madd = W'((m - n) << s);
      msub = W'((1 << fw) - ne);
    end
    @(negedge clk);
    check("R2", wide ? int'(pulse_w) : int'(pulse), 0, {ctx, " idle pulse"});
    check("R2", wide ? int'(dclk_w) : int'(dclk), 0, {ctx, " idle clk"});
    run = 1'b1;
    a = 0;
    for (int c = 0; c < 2 * m; c++) begin
      @(negedge clk);
      if (a < ne) begin p = 1; a = a + me - ne; end
      else        begin p = 0; a = a - ne; end
      ec = str ? int'(2 * a < me) : p;
      ap = wide ? int'(pulse_w) : int'(pulse);
      ac = wide ? int'(dclk_w) : int'(dclk);
      if (wide) check("R10", ap, p, ctx);
      else if (((1 << fw) - ne) % (1 << fw) == 0) check("R3", ap, p, ctx);
      else check("R5", ap, p, ctx);
      if (str) check("R7", ac, ec, ctx);
      else     check("R8", ac, ec, ctx);
      seq[c] = ap[0];
      npulse += ap;
    end
    @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    #(4ns * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] s0, s1;
    int np0, np1, smax;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check("R1", int'(pulse), 0, "reset pulse");
    check("R1", int'(dclk), 0, "reset clk");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(pulse | dclk), 0, "after reset release");

    for (int m = 1; m <= 16; m++) begin
      for (int n = 1; n <= m; n++) begin
        smax = 0;
        while (((n << (smax + 1)) <= (1 << W)) &&
               (((m - n) << (smax + 1)) < (1 << W))) smax++;
        for (int st = 0; st < 2; st++) begin
          run_cfg(1'b0, n, m, 0, st[0], s0, np0);
          run_cfg(1'b0, n, m, smax, st[0], s1, np1);
          check("R4", np0, 2 * n, $sformatf("rate n=%0d m=%0d", n, m));
          check("R4", np1, 2 * n, $sformatf("rate shifted n=%0d m=%0d", n, m));
          checks++;
          if (s0 != s1) begin
            failures++;
            $display("FAIL R6 n=%0d m=%0d actual=%h expected=%h", n, m, s1, s0);
          end
          if (n == m) check("R9", np0, 2 * m, $sformatf("unity m=%0d", m));
        end
      end
    end

    // R10: wide fields, ratios needing more than 8 bits after shifting
    run_cfg(1'b1, 12, 13, 9, 1'b0, s0, np0);
    check("R10", np0, 24, "wide 12/13 rate");
    run_cfg(1'b1, 12, 13, 0, 1'b0, s1, np1);
    checks++;
    if (s0 != s1) begin
      failures++;
      $display("FAIL R10 wide shift actual=%h expected=%h", s0, s1);
    end
    run_cfg(1'b1, 3, 29, 8, 1'b1, s0, np0);
    check("R10", np0, 6, "wide 3/29 rate");
    run_cfg(1'b1, 1, 1, 13, 1'b0, s0, np0);
    check("R10", np0, 2, "wide subtract field zero");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule